// File: doc/BRIEF.md
# Stateful Two-Input Boolean Operation Executor

This block is a cycle-level digital model of a small in-memory logic unit. Two input cells and two scratch cells hold one bit each. The only write primitive is a conditional set: a step first clears its target cell to 0, then sets it to 1 if a condition on one or two source cells holds. A source cell may also be the target. Any of the 16 two-input Boolean functions is evaluated by a short micro-program of one to three such steps, selected by a 4-bit operation code.

A caller presents the operation code and the two input bits, then pulses `start_i` while the unit is idle. The unit loads the cells and runs one step per clock. At the end it raises `done_o` for one cycle, together with the result, the number of steps used and the final contents of both input cells. Some operations write their result back into an input cell, so the reported input state shows which inputs were consumed. All outputs hold their values until the next accepted start.

Top module: `boolx_exec`

## Requirements
- R1: The operation code is the function's truth table. The result equals bit `op_i[{a_i,b_i}]`, where `a_i` is the index MSB. For example, 4'b0111 is NAND, 4'b0110 is XOR and 4'b1011 is "A implies B".
- R2: A `start_i` sampled while idle loads the cells and raises `busy_o` at that edge. One step runs on each following edge. `done_o` is high for exactly one cycle, rising on the same edge on which `busy_o` falls, N edges after the load edge, where N is the step count.
- R3: `steps_o` reports the step count. It is 1 for codes 0000, 1111, 0001, 0111, 0011, 0101, 1011, 0100, 1101 and 0010. It is 2 for COPY A (1100), COPY B (1010), AND (1000) and OR (1110). It is 3 for XOR (0110) and XNOR (1001).
- R4: The four implication-family codes overwrite an input with the result. 1011 (A implies B) and 0010 (B and not A) leave the result in cell B. 0100 (A and not B) and 1101 (B implies A) leave the result in cell A. The other input cell keeps its loaded value.
- R5: XOR leaves its result in cell A and XNOR leaves its result in cell B. In both cases the other input cell is preserved.
- R6: All other codes report both input cells unchanged from the loaded `a_i` and `b_i`.
- R7: A `start_i` asserted while `busy_o` is high is ignored. The running operation completes with its own result and latency, and no further operation follows it.
- R8: While idle and with no start, `result_o`, `steps_o`, `cell_a_o` and `cell_b_o` hold their values, whatever `op_i`, `a_i` and `b_i` do.
- R9: Synchronous active-high reset clears `busy_o`, `done_o`, `result_o`, `steps_o`, `cell_a_o` and `cell_b_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts an operation when idle |
| op_i | input | 4 | Operation code (truth table of the function) |
| a_i | input | 1 | Value loaded into input cell A |
| b_i | input | 1 | Value loaded into input cell B |
| busy_o | output | 1 | Micro-program in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 1 | Content of the result cell |
| steps_o | output | 2 | Steps executed by the last operation |
| cell_a_o | output | 1 | Current content of input cell A |
| cell_b_o | output | 1 | Current content of input cell B |

## Verification
Every operation code is run on all four input pairs. The four pairs separate each code from every other truth table, and they show which input cell a destructive code overwrites, because the written value differs from the loaded value only for some pairs. Each run also measures latency, which separates the one-, two- and three-step programs. A start issued during a three-step run checks that a busy unit ignores new requests. Input changes while the unit is idle check that the reported state holds.

// File: rtl/boolx_pkg.sv
package boolx_pkg;

    localparam int OP_W      = 4;
    localparam int NUM_CELLS = 4;
    localparam int MAX_STEPS = 3;
    localparam int CELL_W    = $clog2(NUM_CELLS);
    localparam int STEP_W    = $clog2(MAX_STEPS + 1);

    typedef enum logic [CELL_W-1:0] {
        C_A  = 2'd0,
        C_B  = 2'd1,
        C_S1 = 2'd2,
        C_S2 = 2'd3
    } cell_e;

    // Conditional-set primitives: target cleared, then set when condition holds
    typedef enum logic [2:0] {
        PR_CLR,   // never set
        PR_SET,   // always set
        PR_INV,   // set when s1 == 0
        PR_NAND,  // set unless s1 & s2
        PR_NOR,   // set when s1 == 0 and s2 == 0
        PR_IMP,   // set when !s1 | s2
        PR_NIMP   // set when s1 & !s2
    } prim_e;

    typedef struct packed {
        prim_e prim;
        cell_e dst;
        cell_e s1;
        cell_e s2;
    } uop_t;

    typedef struct packed {
        logic [STEP_W-1:0]       len;
        uop_t [MAX_STEPS-1:0]    seq;
    } prog_t;

    function automatic uop_t mk(prim_e p, cell_e d, cell_e x, cell_e y);
        uop_t u;
        u.prim = p;
        u.dst  = d;
        u.s1   = x;
        u.s2   = y;
        return u;
    endfunction

    function automatic logic prim_eval(prim_e p, logic x, logic y);
        logic v;
        v = 1'b0;
        unique case (p)
            PR_SET:  v = 1'b1;
            PR_INV:  v = !x;
            PR_NAND: v = !(x && y);
            PR_NOR:  v = !(x || y);
            PR_IMP:  v = !x || y;
            PR_NIMP: v = x && !y;
            default: v = 1'b0;
        endcase
        return v;
    endfunction

    function automatic prog_t program_of(logic [OP_W-1:0] op);
        prog_t p;
        p = '0;
        unique case (op)
            4'b0000: begin p.len = 2'd1; p.seq[0] = mk(PR_CLR,  C_S1, C_A, C_A); end
            4'b1111: begin p.len = 2'd1; p.seq[0] = mk(PR_SET,  C_S1, C_A, C_A); end
            4'b0001: begin p.len = 2'd1; p.seq[0] = mk(PR_NOR,  C_S1, C_A, C_B); end
            4'b0111: begin p.len = 2'd1; p.seq[0] = mk(PR_NAND, C_S1, C_A, C_B); end
            4'b0011: begin p.len = 2'd1; p.seq[0] = mk(PR_INV,  C_S1, C_A, C_A); end
            4'b0101: begin p.len = 2'd1; p.seq[0] = mk(PR_INV,  C_S1, C_B, C_B); end
            4'b1011: begin p.len = 2'd1; p.seq[0] = mk(PR_IMP,  C_B,  C_A, C_B); end
            4'b0100: begin p.len = 2'd1; p.seq[0] = mk(PR_NIMP, C_A,  C_A, C_B); end
            4'b1101: begin p.len = 2'd1; p.seq[0] = mk(PR_IMP,  C_A,  C_B, C_A); end
            4'b0010: begin p.len = 2'd1; p.seq[0] = mk(PR_NIMP, C_B,  C_B, C_A); end
            4'b1100: begin
                p.len = 2'd2;
                p.seq[0] = mk(PR_INV, C_S1, C_A,  C_A);
                p.seq[1] = mk(PR_INV, C_S2, C_S1, C_S1);
            end
            4'b1010: begin
                p.len = 2'd2;
                p.seq[0] = mk(PR_INV, C_S1, C_B,  C_B);
                p.seq[1] = mk(PR_INV, C_S2, C_S1, C_S1);
            end
            4'b1000: begin
                p.len = 2'd2;
                p.seq[0] = mk(PR_NAND, C_S1, C_A,  C_B);
                p.seq[1] = mk(PR_INV,  C_S2, C_S1, C_S1);
            end
            4'b1110: begin
                p.len = 2'd2;
                p.seq[0] = mk(PR_NOR, C_S1, C_A,  C_B);
                p.seq[1] = mk(PR_INV, C_S2, C_S1, C_S1);
            end
            4'b0110: begin
                p.len = 2'd3;
                p.seq[0] = mk(PR_NOR,  C_S1, C_A,  C_B);
                p.seq[1] = mk(PR_NAND, C_S2, C_A,  C_B);
                p.seq[2] = mk(PR_NIMP, C_A,  C_S2, C_S1);
            end
            default: begin // 4'b1001
                p.len = 2'd3;
                p.seq[0] = mk(PR_NOR,  C_S1, C_A,  C_B);
                p.seq[1] = mk(PR_NAND, C_S2, C_A,  C_B);
                p.seq[2] = mk(PR_IMP,  C_B,  C_S2, C_S1);
            end
        endcase
        return p;
    endfunction

    function automatic cell_e result_cell(prog_t p);
        cell_e c;
        unique case (p.len)
            2'd2:    c = p.seq[1].dst;
            2'd3:    c = p.seq[2].dst;
            default: c = p.seq[0].dst;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/boolx_seq.sv
module boolx_seq
    import boolx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [STEP_W-1:0] len_i,
    output logic              load_o,
    output logic              exec_o,
    output logic [STEP_W-1:0] idx_o,
    output logic [STEP_W-1:0] steps_o,
    output logic              busy_o,
    output logic              done_o
);

    logic              busy_q;
    logic              done_q;
    logic [STEP_W-1:0] idx_q;
    logic [STEP_W-1:0] steps_q;
    logic              last_step;

    assign load_o    = start_i && !busy_q;
    assign exec_o    = busy_q;
    assign last_step = (STEP_W'(idx_q + 1'b1) == len_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            idx_q   <= '0;
            steps_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                busy_q  <= 1'b1;
                idx_q   <= '0;
                steps_q <= '0;
            end else if (busy_q) begin
                idx_q   <= STEP_W'(idx_q + 1'b1);
                steps_q <= STEP_W'(steps_q + 1'b1);
                if (last_step) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign idx_o   = idx_q;
    assign steps_o = steps_q;
    assign busy_o  = busy_q;
    assign done_o  = done_q;

endmodule

// File: rtl/boolx_cells.sv
module boolx_cells
    import boolx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic                 a_i,
    input  logic                 b_i,
    input  logic                 exec_i,
    input  uop_t                 uop_i,
    output logic [NUM_CELLS-1:0] cells_o
);

    logic [NUM_CELLS-1:0] cells_q;
    logic                 set_val;

    // Target is preset to 0 and set to 1 only when the condition holds
    assign set_val = prim_eval(uop_i.prim, cells_q[uop_i.s1], cells_q[uop_i.s2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cells_q <= '0;
        end else if (load_i) begin
            cells_q       <= '0;
            cells_q[C_A]  <= a_i;
            cells_q[C_B]  <= b_i;
        end else if (exec_i) begin
            cells_q[uop_i.dst] <= set_val;
        end
    end

    assign cells_o = cells_q;

endmodule

// File: rtl/boolx_exec.sv
module boolx_exec
    import boolx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [3:0] op_i,
    input  logic       a_i,
    input  logic       b_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       result_o,
    output logic [1:0] steps_o,
    output logic       cell_a_o,
    output logic       cell_b_o
);

    logic [OP_W-1:0]      op_q;
    prog_t                prog;
    uop_t                 cur_uop;
    logic                 load;
    logic                 exec;
    logic [STEP_W-1:0]    idx;
    logic [STEP_W-1:0]    steps;
    logic [NUM_CELLS-1:0] cells;

    always_ff @(posedge clk) begin
        if (rst)       op_q <= '0;
        else if (load) op_q <= op_i;
    end

    assign prog = program_of(op_q);

    always_comb begin
        cur_uop = '0;
        for (int k = 0; k < MAX_STEPS; k++) begin
            if (idx == STEP_W'(k)) cur_uop = prog.seq[k];
        end
    end

    boolx_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .len_i   (prog.len),
        .load_o  (load),
        .exec_o  (exec),
        .idx_o   (idx),
        .steps_o (steps),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    boolx_cells u_cells (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .a_i     (a_i),
        .b_i     (b_i),
        .exec_i  (exec),
        .uop_i   (cur_uop),
        .cells_o (cells)
    );

    assign result_o = cells[result_cell(prog)];
    assign steps_o  = steps;
    assign cell_a_o = cells[C_A];
    assign cell_b_o = cells[C_B];

endmodule

// File: rtl/boolx_exec_chk.sv
module boolx_exec_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic [3:0] op_i,
    input logic       a_i,
    input logic       b_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       result_o,
    input logic [1:0] steps_o,
    input logic       cell_a_o,
    input logic       cell_b_o
);

    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    p_launch_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && steps_o == 2'd0));

    p_steps_range_r3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (steps_o != 2'd0));

    p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (steps_o != 2'd0));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(result_o) && $stable(steps_o)
                                   && $stable(cell_a_o) && $stable(cell_b_o)));

endmodule

bind boolx_exec boolx_exec_chk u_chk (.*);

// File: tb/tb_boolx_exec.sv
module tb_boolx_exec;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic       a_i = 1'b0;
    logic       b_i = 1'b0;
    logic       busy_o, done_o, result_o, cell_a_o, cell_b_o;
    logic [1:0] steps_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int launch = 0;

    typedef struct {
        logic [3:0] op;
        logic       a;
        logic       b;
        logic       res;
        int         steps;
        logic       fa;
        logic       fb;
    } exp_t;

    exp_t sb[$];
    exp_t last_exp;

    boolx_exec dut (.*);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic exp_t model(logic [3:0] op, logic a, logic b);
        exp_t e;
        e.op = op; e.a = a; e.b = b;
        e.res = op[{a, b}];
        case (op)
            4'b1100, 4'b1010, 4'b1000, 4'b1110: e.steps = 2;
            4'b0110, 4'b1001:                   e.steps = 3;
            default:                            e.steps = 1;
        endcase
        e.fa = a; e.fb = b;
        case (op)
            4'b1011, 4'b0010, 4'b1001: e.fb = e.res;
            4'b0100, 4'b1101, 4'b0110: e.fa = e.res;
            default: ;
        endcase
        return e;
    endfunction

    function automatic string cell_req(logic [3:0] op);
        if (op == 4'b1011 || op == 4'b0010 || op == 4'b0100 || op == 4'b1101) return "R4";
        if (op == 4'b0110 || op == 4'b1001) return "R5";
        return "R6";
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each completion pulse
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (sb.size() == 0) begin
                chk("R7", "unexpected completion", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R1", $sformatf("result op=%b ab=%b%b", e.op, e.a, e.b), result_o, e.res);
                chk("R3", $sformatf("steps op=%b", e.op), steps_o, e.steps);
                chk("R2", $sformatf("latency op=%b", e.op), cyc - launch, e.steps);
                chk(cell_req(e.op), $sformatf("cell A op=%b ab=%b%b", e.op, e.a, e.b), cell_a_o, e.fa);
                chk(cell_req(e.op), $sformatf("cell B op=%b ab=%b%b", e.op, e.a, e.b), cell_b_o, e.fb);
                last_exp = e;
            end
        end
    end

    task automatic wait_drain();
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic run_op(logic [3:0] op, logic a, logic b);
        sb.push_back(model(op, a, b));
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        launch = cyc;
        chk("R2", "busy after start", busy_o, 1);
        wait_drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9", "busy in reset", busy_o, 0);
        chk("R9", "done in reset", done_o, 0);
        chk("R9", "result in reset", result_o, 0);
        chk("R9", "steps in reset", steps_o, 0);
        chk("R9", "cell A in reset", cell_a_o, 0);
        chk("R9", "cell B in reset", cell_b_o, 0);
        rst = 1'b0;

        for (int op = 0; op < 16; op++) begin
            for (int ab = 0; ab < 4; ab++) begin
                run_op(4'(op), ab[1], ab[0]);
            end
        end

        // R8: idle outputs hold while inputs move
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            op_i = 4'(k * 3); a_i = k[0]; b_i = !k[0];
        end
        @(negedge clk);
        chk("R8", "held result", result_o, last_exp.res);
        chk("R8", "held steps", steps_o, last_exp.steps);
        chk("R8", "held cell A", cell_a_o, last_exp.fa);
        chk("R8", "held cell B", cell_b_o, last_exp.fb);

        // R7: start during a three-step XOR run is ignored
        sb.push_back(model(4'b0110, 1'b1, 1'b0));
        @(negedge clk);
        op_i = 4'b0110; a_i = 1'b1; b_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        launch = cyc;
        op_i = 4'b1000; a_i = 1'b1; b_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_drain();
        repeat (4) @(negedge clk);
        chk("R7", "no second run", busy_o, 0);
        chk("R7", "result kept", result_o, 1);

        if (sb.size() != 0) chk("R2", "pending items", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule